// File: doc/BRIEF.md
# Two-Dimensional Transfer Run Controller

This block is the control sequencer for a two-dimensional memory transfer engine and its two colour lookup-table loaders. Each of the three channels has its own start bit. Software sets that bit to launch the channel. While the channel is running, the block drives a run enable to the channel's datapath. It waits for the datapath's done strobe, then clears the start bit itself and raises a sticky completion flag. A completion flag raises the interrupt line when its enable bit is set. The flag stays set until software writes a one to clear it.

A suspend bit and an abort bit are shared by all channels. Setting suspend removes every run enable, so the datapath counters hold their values. Clearing suspend lets the channels carry on from where they stopped. Abort can be written at any time, including during a suspend. A busy channel then passes through one flush cycle and returns to idle with its start bit cleared. An aborted channel never raises its completion flag.

Channel 0 is the main transfer, channel 1 is the foreground lookup-table load and channel 2 is the background lookup-table load. All per-channel vectors use that bit order.

Top module: `xfer_ctrl`

## Requirements
- R1: After reset, all start bits, run enables, completion flags and interrupt enables are 0, and the suspend bit, the abort bit and the interrupt line are 0.
- R2: A start write to an idle channel, with abort clear and suspend clear, sets that channel's start_o and run_o in the next cycle.
- R3: A done strobe seen while a channel's run_o is high clears that channel's start_o and run_o in the next cycle and sets its completion flag. A channel started with a datapath of N units therefore runs for exactly N cycles.
- R4: irq_o is high exactly when some channel has both its completion flag and its interrupt enable bit set.
- R5: A completion flag stays set until a write of 1 to that channel's clear bit. The flag and the interrupt drop in the next cycle. If a new completion arrives in the same cycle as the clear, the flag stays set.
- R6: While suspend_o is 1, every run_o is 0, start bits keep their values, and a done strobe has no effect.
- R7: When suspend is cleared by a write at edge k, run_o of a suspended channel returns at edge k+1. The transfer then completes after only its remaining units.
- R8: An abort write at edge a drops run_o right after edge a. A busy channel, running or suspended, keeps start_o high for one flush cycle and clears it at edge a+2. Its completion flag does not rise.
- R9: abort_o reads 1 from the edge after the abort write. It clears itself once no channel is running or suspended. Start writes made while abort_o is 1 are ignored.
- R10: The three channels start and complete independently and each sets only its own completion flag.
- R11: A start write to a channel that is already busy has no effect on its progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_set_i | input | NCH | Write 1 to set a channel's start bit |
| susp_wr_i | input | 1 | Write strobe for the suspend bit |
| susp_val_i | input | 1 | Value written to the suspend bit |
| abort_set_i | input | 1 | Write 1 to request abort |
| irq_en_wr_i | input | 1 | Write strobe for the interrupt enable vector |
| irq_en_val_i | input | NCH | Value written to the interrupt enables |
| tc_clr_i | input | NCH | Write 1 to clear a channel's completion flag |
| dp_done_i | input | NCH | Done strobe from each channel's datapath |
| run_o | output | NCH | Run enable to each channel's datapath |
| start_o | output | NCH | Readable start bits |
| susp_o | output | 1 | Readable suspend bit |
| abort_o | output | 1 | Readable abort bit |
| tc_flag_o | output | NCH | Sticky completion flags |
| irq_en_o | output | NCH | Readable interrupt enables |
| irq_o | output | 1 | Interrupt line |

## Verification
Several rules are checked by assertions on every cycle. A done strobe taken during a run always ends the run with the flag set, and suspend or abort always removes every run enable. A flag never drops without a clear, and abort never lets a flag rise. A start bit never appears while abort is pending, and a busy start bit persists until done or abort. Some behaviour is visible only through the bench's scenarios, which drive a counting datapath model. These cover the exact number of run cycles, the one-cycle resume latency, the flush timing, the self-clearing of the abort bit and the independence of the lookup-table channels.

// File: rtl/xfer_ctrl_pkg.sv
`timescale 1ns/1ps
package xfer_ctrl_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_HOLD  = 2'd2,
    CH_FLUSH = 2'd3
  } ch_state_e;
endpackage

// File: rtl/xfer_chan_fsm.sv
`timescale 1ns/1ps
module xfer_chan_fsm
  import xfer_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_set_i,
  input  logic susp_i,
  input  logic abort_i,
  input  logic done_i,
  output logic run_o,
  output logic start_o,
  output logic busy_o,
  output logic cmpl_o
);
  ch_state_e state_q, state_d;

  assign run_o   = (state_q == CH_RUN) && !susp_i && !abort_i;
  assign cmpl_o  = run_o && done_i;
  assign start_o = (state_q != CH_IDLE);
  assign busy_o  = (state_q == CH_RUN) || (state_q == CH_HOLD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CH_IDLE:  if (start_set_i && !abort_i) state_d = susp_i ? CH_HOLD : CH_RUN;
      CH_RUN: begin
        if (abort_i)     state_d = CH_FLUSH;
        else if (susp_i) state_d = CH_HOLD;
        else if (done_i) state_d = CH_IDLE;
      end
      CH_HOLD: begin
        if (abort_i)      state_d = CH_FLUSH;
        else if (!susp_i) state_d = CH_RUN;
      end
      // one cycle for the datapath to drain before start clears
      CH_FLUSH: state_d = CH_IDLE;
      default:  state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CH_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/xfer_flag_irq.sv
`timescale 1ns/1ps
module xfer_flag_irq #(
  parameter int NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  input  logic           en_wr_i,
  input  logic [NCH-1:0] en_val_i,
  output logic [NCH-1:0] flag_o,
  output logic [NCH-1:0] en_o,
  output logic           irq_o
);
  logic [NCH-1:0] flag_q, en_q;

  for (genvar c = 0; c < NCH; c++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[c] <= 1'b0;
      else if (set_i[c])  flag_q[c] <= 1'b1;  // completion wins over clear
      else if (clr_i[c])  flag_q[c] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_wr_i) en_q <= en_val_i;
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = |(flag_q & en_q);
endmodule

// File: rtl/xfer_ctrl.sv
`timescale 1ns/1ps
module xfer_ctrl #(
  parameter int NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] start_set_i,
  input  logic           susp_wr_i,
  input  logic           susp_val_i,
  input  logic           abort_set_i,
  input  logic           irq_en_wr_i,
  input  logic [NCH-1:0] irq_en_val_i,
  input  logic [NCH-1:0] tc_clr_i,
  input  logic [NCH-1:0] dp_done_i,
  output logic [NCH-1:0] run_o,
  output logic [NCH-1:0] start_o,
  output logic           susp_o,
  output logic           abort_o,
  output logic [NCH-1:0] tc_flag_o,
  output logic [NCH-1:0] irq_en_o,
  output logic           irq_o
);
  logic           susp_q, abort_q;
  logic [NCH-1:0] busy, cmpl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        susp_q <= 1'b0;
    else if (susp_wr_i) susp_q <= susp_val_i;
  end

  // abort holds until no channel is running or held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) abort_q <= 1'b0;
    else         abort_q <= abort_set_i | (abort_q & (|busy));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    xfer_chan_fsm u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_set_i (start_set_i[c]),
      .susp_i      (susp_q),
      .abort_i     (abort_q),
      .done_i      (dp_done_i[c]),
      .run_o       (run_o[c]),
      .start_o     (start_o[c]),
      .busy_o      (busy[c]),
      .cmpl_o      (cmpl[c])
    );
  end

  xfer_flag_irq #(.NCH(NCH)) u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (cmpl),
    .clr_i    (tc_clr_i),
    .en_wr_i  (irq_en_wr_i),
    .en_val_i (irq_en_val_i),
    .flag_o   (tc_flag_o),
    .en_o     (irq_en_o),
    .irq_o    (irq_o)
  );

  assign susp_o  = susp_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/xfer_ctrl_chk.sv
`timescale 1ns/1ps
module xfer_ctrl_chk #(
  parameter int NCH = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] start_set_i,
  input logic [NCH-1:0] tc_clr_i,
  input logic [NCH-1:0] dp_done_i,
  input logic [NCH-1:0] run_o,
  input logic [NCH-1:0] start_o,
  input logic           susp_o,
  input logic           abort_o,
  input logic [NCH-1:0] tc_flag_o,
  input logic           irq_o
);
  // R6
  susp_stops_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> (run_o == '0));

  // R8
  abort_stops_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (run_o == '0));

  // R4
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_flag_o == '0) |-> !irq_o);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R3
    done_ends_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_o[c] && dp_done_i[c]) |=> (!start_o[c] && tc_flag_o[c]));

    // R5
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tc_flag_o[c] && !tc_clr_i[c]) |=> tc_flag_o[c]);

    // R8
    abort_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (abort_o && !tc_flag_o[c]) |=> !tc_flag_o[c]);

    // R9
    abort_blocks_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (abort_o && !start_o[c]) |=> !start_o[c]);

    // R11
    busy_holds_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_o[c] && !abort_o && !(run_o[c] && dp_done_i[c]) && !susp_o) |=> start_o[c]);
  end
endmodule

bind xfer_ctrl xfer_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_set_i (start_set_i),
  .tc_clr_i    (tc_clr_i),
  .dp_done_i   (dp_done_i),
  .run_o       (run_o),
  .start_o     (start_o),
  .susp_o      (susp_o),
  .abort_o     (abort_o),
  .tc_flag_o   (tc_flag_o),
  .irq_o       (irq_o)
);

// File: tb/xfer_ctrl_test.sv
`timescale 1ns/1ps
module xfer_ctrl_test;
  localparam int NCH = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] start_set = '0;
  logic           susp_wr = 1'b0, susp_val = 1'b0, abort_set = 1'b0;
  logic           en_wr = 1'b0;
  logic [NCH-1:0] en_val = '0, tc_clr = '0, force_done = '0;
  logic [NCH-1:0] dp_done, run, start, tc_flag, irq_en;
  logic           susp, abort, irq;

  int n_chk = 0, n_fail = 0;
  int len [NCH];
  int cnt [NCH];

  always #2.5 clk = ~clk;

  xfer_ctrl #(.NCH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_set_i(start_set),
    .susp_wr_i(susp_wr), .susp_val_i(susp_val), .abort_set_i(abort_set),
    .irq_en_wr_i(en_wr), .irq_en_val_i(en_val), .tc_clr_i(tc_clr),
    .dp_done_i(dp_done), .run_o(run), .start_o(start), .susp_o(susp),
    .abort_o(abort), .tc_flag_o(tc_flag), .irq_en_o(irq_en), .irq_o(irq)
  );

  // datapath model: counts units while enabled, done on the last unit
  for (genvar c = 0; c < NCH; c++) begin : g_dp
    assign dp_done[c] = force_done[c] | (run[c] && (cnt[c] == len[c] - 1));
    always @(posedge clk) begin
      if (!start[c])                cnt[c] <= 0;
      else if (run[c] && dp_done[c]) cnt[c] <= 0;
      else if (run[c])              cnt[c] <= cnt[c] + 1;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic launch(input int ch, input int n);
    len[ch] = n;
    start_set[ch] = 1'b1;
    tick();
    start_set[ch] = 1'b0;
  endtask

  // remaining units complete in exactly `left` cycles
  task automatic finish_in(input int ch, input int left, input string req);
    repeat (left - 1) tick();
    chk({req, " start still set"}, start[ch], 1);
    tick();
    chk({req, " start cleared"}, start[ch], 0);
    chk({req, " run cleared"}, run[ch], 0);
    chk({req, " flag set"}, tc_flag[ch], 1);
  endtask

  task automatic write_susp(input logic v);
    susp_wr = 1'b1; susp_val = v;
    tick();
    susp_wr = 1'b0;
  endtask

  task automatic clear_flags();
    tc_clr = '1;
    tick();
    tc_clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 start", start, 0);
    chk("R1 run", run, 0);
    chk("R1 flags", tc_flag, 0);
    chk("R1 enables", irq_en, 0);
    chk("R1 susp/abort/irq", {susp, abort, irq}, 0);
  endtask

  task automatic t_basic();
    launch(0, 5);
    chk("R2 start set", start[0], 1);
    chk("R2 run set", run[0], 1);
    finish_in(0, 5, "R3");
    chk("R4 irq off without enable", irq, 0);
    en_wr = 1'b1; en_val = 3'b001;
    tick();
    en_wr = 1'b0;
    chk("R4 irq with enable", irq, 1);
    tc_clr[0] = 1'b1;
    tick();
    tc_clr[0] = 1'b0;
    chk("R5 flag cleared", tc_flag[0], 0);
    chk("R5 irq dropped", irq, 0);
  endtask

  task automatic t_set_wins();
    launch(0, 2);
    finish_in(0, 2, "R3 short");
    launch(0, 2);
    tick();                  // done strobe now high
    tc_clr[0] = 1'b1;
    tick();
    tc_clr[0] = 1'b0;
    chk("R5 set wins over clear", tc_flag[0], 1);
    repeat (2) tick();
    chk("R5 flag sticky", tc_flag[0], 1);
    clear_flags();
  endtask

  task automatic t_suspend();
    launch(0, 8);
    repeat (2) tick();
    write_susp(1'b1);
    chk("R6 susp read", susp, 1);
    chk("R6 run low", run[0], 0);
    force_done[0] = 1'b1;
    tick();
    force_done[0] = 1'b0;
    tick();
    chk("R6 done ignored start", start[0], 1);
    chk("R6 done ignored flag", tc_flag[0], 0);
    chk("R6 counter held", cnt[0], 3);
    write_susp(1'b0);
    chk("R7 run still low first cycle", run[0], 0);
    tick();
    chk("R7 run resumed", run[0], 1);
    finish_in(0, 5, "R7");
    clear_flags();
  endtask

  task automatic t_abort_run();
    launch(0, 20);
    repeat (2) tick();
    abort_set = 1'b1;
    tick();
    abort_set = 1'b0;
    chk("R8 run dropped", run[0], 0);
    chk("R9 abort read", abort, 1);
    tick();
    chk("R8 flush keeps start", start[0], 1);
    tick();
    chk("R8 start cleared", start[0], 0);
    chk("R8 no flag", tc_flag[0], 0);
    chk("R9 abort self-cleared", abort, 0);
  endtask

  task automatic t_abort_susp();
    launch(0, 20);
    write_susp(1'b1);
    tick();
    abort_set = 1'b1;
    tick();
    abort_set = 1'b0;
    chk("R8 suspended abort read", abort, 1);
    tick();
    chk("R8 suspended flush start", start[0], 1);
    tick();
    chk("R8 suspended start cleared", start[0], 0);
    chk("R8 suspended no flag", tc_flag[0], 0);
    write_susp(1'b0);
  endtask

  task automatic t_abort_blocks();
    abort_set = 1'b1;
    tick();
    abort_set = 1'b0;
    start_set[0] = 1'b1;
    len[0] = 4;
    tick();
    start_set[0] = 1'b0;
    chk("R9 start ignored during abort", start[0], 0);
    chk("R9 abort cleared when idle", abort, 0);
  endtask

  task automatic t_restart();
    launch(0, 6);
    repeat (2) tick();
    start_set[0] = 1'b1;
    tick();
    start_set[0] = 1'b0;
    finish_in(0, 3, "R11");
    clear_flags();
  endtask

  task automatic t_channels();
    en_wr = 1'b1; en_val = 3'b010;
    tick();
    en_wr = 1'b0;
    len[1] = 3; len[2] = 6;
    start_set = 3'b110;
    tick();
    start_set = '0;
    chk("R10 both run", run, 3'b110);
    repeat (3) tick();
    chk("R10 fg done only", tc_flag, 3'b010);
    chk("R10 bg still busy", start, 3'b100);
    chk("R10 irq from fg", irq, 1);
    repeat (3) tick();
    chk("R10 bg done", tc_flag, 3'b110);
    chk("R10 main untouched", start[0], 0);
    clear_flags();
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) len[c] = 1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_set_wins();
    t_suspend();
    t_abort_run();
    t_abort_susp();
    t_abort_blocks();
    t_restart();
    t_channels();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule